// File: doc/BRIEF.md
# Legacy Level-Interrupt Pin Tracker with Software Disable

This block keeps the asserted level of the four legacy level-sensitive interrupt pins of a bus function. The device logic presents a level request for each pin every cycle. The block stores these levels and drives the interrupt-status flag of the status register from them. It also forwards signed level-change events (+1 when a pin starts to contribute to its shared line, −1 when it stops) to a downstream aggregator that counts contributions per line.

The command register holds the I/O-space, memory-space and bus-master enables, plus an interrupt-disable flag. While the disable flag is set, pin changes still update the stored levels and the status flag, but no events are forwarded. When software flips the disable flag, the block withdraws (on set) or restores (on clear) the contribution of every pin that is asserted at that moment. Events go out one per cycle, lowest pin first.

Internally the block compares the contribution each pin should have with the contribution it has already forwarded, and emits one correction per cycle. Every event the aggregator sees therefore leaves the aggregator consistent with the current pin levels and disable flag.

Top module: `legacy_irq_gate`

## Requirements
- R1: At each clock edge the stored pin levels take the value of `pin_req`. `irq_status` is high in the cycle after that edge exactly when any stored level is 1, whether or not interrupts are disabled.
- R2: A pin request equal to the stored level of that pin produces no event.
- R3: While the disable flag is clear, a change of pin p is reported in the cycle after the edge that stores it. The report has `evt_valid`=1 and `evt_pin`=p, where 0..3 are pins A..D. `evt_delta` is 2'b01 (+1) for a rise and 2'b11 (−1) for a fall.
- R4: While the disable flag is set, pin changes produce no event, and `evt_delta` is never +1.
- R5: A command write that changes the disable flag (bit 10) from 0 to 1 produces one −1 event for each pin asserted at that time.
- R6: A command write that changes the disable flag from 1 to 0 produces one +1 event for each asserted pin. A write that leaves the flag unchanged produces no event.
- R7: When several events are outstanding, they appear on consecutive cycles, one per cycle, in ascending pin order, and no event is repeated.
- R8: A command write stores only bits 0 (I/O enable), 1 (memory enable), 2 (bus-master enable) and 10 (interrupt disable). All other bits of `cmd_q` read 0. `cmd_q` shows the written value in the cycle after the write.
- R9: Synchronous reset clears all pin levels, the status flag, the three enables and the disable flag, and leaves no event outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_req | input | 4 | Requested level per pin, bit 0 = pin A |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 16 | Command register write data |
| cmd_q | output | 16 | Current command register value |
| irq_status | output | 1 | Interrupt-status flag (status register bit 3) |
| evt_valid | output | 1 | A level-change event is presented this cycle |
| evt_pin | output | 2 | Pin index of the event |
| evt_delta | output | 2 | Signed change: 2'b01 = +1, 2'b11 = −1 |

## Verification
The bench sweeps every transition between each pair of 4-bit pin patterns, once with the disable flag clear and once with it set. A design that compared against the request rather than the stored level, or that leaked events while disabled, would report spurious or missing events in this sweep. For every pin pattern it also toggles the disable flag both ways and expects the exact ordered train of withdrawals or restorations. A design that sent all events at once, used the wrong order, or forgot pins asserted before the toggle would break that train. Further checks cover writes that leave the flag unchanged, masking of the non-writable command bits, and a reset taken while pins are asserted.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

    localparam int NUM_PINS   = 4;
    localparam int CMD_W      = 16;

    localparam int CMD_IO_BIT      = 0;
    localparam int CMD_MEM_BIT     = 1;
    localparam int CMD_BM_BIT      = 2;
    localparam int CMD_IRQ_OFF_BIT = 10;
    localparam int STS_IRQ_BIT     = 3;

    localparam logic [CMD_W-1:0] CMD_WMASK =
        (CMD_W'(1) << CMD_IO_BIT)  | (CMD_W'(1) << CMD_MEM_BIT) |
        (CMD_W'(1) << CMD_BM_BIT)  | (CMD_W'(1) << CMD_IRQ_OFF_BIT);

    typedef enum logic [1:0] {
        DELTA_UP = 2'b01,
        DELTA_DN = 2'b11
    } delta_e;

    function automatic delta_e delta_of(input logic rising);
        return rising ? DELTA_UP : DELTA_DN;
    endfunction

endpackage

// File: rtl/lvl_pin_bank.sv
module lvl_pin_bank #(
    parameter int NPINS = lvl_irq_pkg::NUM_PINS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] req,
    output logic [NPINS-1:0] level_q,
    output logic             any_q
);
    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst) level_q[g] <= 1'b0;
            else     level_q[g] <= req[g];
        end
    end

    assign any_q = |level_q;
endmodule

// File: rtl/lvl_cmd_reg.sv
module lvl_cmd_reg #(
    parameter int               W     = lvl_irq_pkg::CMD_W,
    parameter logic [W-1:0]     WMASK = lvl_irq_pkg::CMD_WMASK,
    parameter int               OFF_BIT = lvl_irq_pkg::CMD_IRQ_OFF_BIT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cmd_q,
    output logic         irq_off
);
    always_ff @(posedge clk) begin
        if (rst)     cmd_q <= '0;
        else if (wr) cmd_q <= wdata & WMASK;
    end

    assign irq_off = cmd_q[OFF_BIT];
endmodule

// File: rtl/lvl_evt_sched.sv
module lvl_evt_sched
    import lvl_irq_pkg::*;
#(
    parameter int NPINS = NUM_PINS,
    localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] level,
    input  logic             irq_off,
    output logic             evt_valid,
    output logic [IDX_W-1:0] evt_pin,
    output delta_e           evt_delta
);
    logic [NPINS-1:0] fwd_q;
    logic [NPINS-1:0] target;
    logic [NPINS-1:0] diff;

    assign target = level & {NPINS{~irq_off}};
    assign diff   = target ^ fwd_q;

    always_comb begin
        evt_valid = 1'b0;
        evt_pin   = '0;
        for (int p = NPINS - 1; p >= 0; p--) begin
            if (diff[p]) begin
                evt_valid = 1'b1;
                evt_pin   = IDX_W'(p);
            end
        end
        evt_delta = delta_of(target[evt_pin]);
    end

    always_ff @(posedge clk) begin
        if (rst)            fwd_q <= '0;
        else if (evt_valid) fwd_q[evt_pin] <= target[evt_pin];
    end
endmodule

// File: rtl/legacy_irq_gate.sv
module legacy_irq_gate
    import lvl_irq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_PINS-1:0]    pin_req,
    input  logic                   cmd_wr,
    input  logic [CMD_W-1:0]       cmd_wdata,
    output logic [CMD_W-1:0]       cmd_q,
    output logic                   irq_status,
    output logic                   evt_valid,
    output logic [$clog2(NUM_PINS)-1:0] evt_pin,
    output logic [1:0]             evt_delta
);
    logic [NUM_PINS-1:0] level_q;
    logic                irq_off;
    delta_e              delta_w;

    lvl_pin_bank #(.NPINS(NUM_PINS)) u_pins (
        .clk     (clk),
        .rst     (rst),
        .req     (pin_req),
        .level_q (level_q),
        .any_q   (irq_status)
    );

    lvl_cmd_reg #(.W(CMD_W), .WMASK(CMD_WMASK), .OFF_BIT(CMD_IRQ_OFF_BIT)) u_cmd (
        .clk     (clk),
        .rst     (rst),
        .wr      (cmd_wr),
        .wdata   (cmd_wdata),
        .cmd_q   (cmd_q),
        .irq_off (irq_off)
    );

    lvl_evt_sched #(.NPINS(NUM_PINS)) u_evt (
        .clk       (clk),
        .rst       (rst),
        .level     (level_q),
        .irq_off   (irq_off),
        .evt_valid (evt_valid),
        .evt_pin   (evt_pin),
        .evt_delta (delta_w)
    );

    assign evt_delta = delta_w;
endmodule

// File: rtl/lvl_irq_checker.sv
module lvl_irq_checker
    import lvl_irq_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic [NUM_PINS-1:0]    pin_req,
    input logic                   cmd_wr,
    input logic [CMD_W-1:0]       cmd_wdata,
    input logic [CMD_W-1:0]       cmd_q,
    input logic                   irq_status,
    input logic                   evt_valid,
    input logic [$clog2(NUM_PINS)-1:0] evt_pin,
    input logic [1:0]             evt_delta
);
    AST_STATUS_TRACKS_PINS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> irq_status == (|$past(pin_req))); // R1

    AST_NO_UP_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_delta == DELTA_UP) |-> !cmd_q[CMD_IRQ_OFF_BIT]); // R4

    AST_NO_REPEAT_EVT: assert property (@(posedge clk) disable iff (rst)
        evt_valid |=> !(evt_valid && evt_pin == $past(evt_pin)
                        && evt_delta == $past(evt_delta))); // R7

    AST_CMD_WRITE_MASKED: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> cmd_q == ($past(cmd_wdata) & CMD_WMASK)); // R8
endmodule

bind legacy_irq_gate lvl_irq_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .pin_req    (pin_req),
    .cmd_wr     (cmd_wr),
    .cmd_wdata  (cmd_wdata),
    .cmd_q      (cmd_q),
    .irq_status (irq_status),
    .evt_valid  (evt_valid),
    .evt_pin    (evt_pin),
    .evt_delta  (evt_delta)
);

// File: tb/sim_legacy_irq_gate.sv
`timescale 1ns/1ps
module sim_legacy_irq_gate;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  pin_req = '0;
    logic        cmd_wr = 1'b0;
    logic [15:0] cmd_wdata = '0;
    logic [15:0] cmd_q;
    logic        irq_status;
    logic        evt_valid;
    logic [1:0]  evt_pin;
    logic [1:0]  evt_delta;

    int checks = 0;
    int errors = 0;
    logic [3:0] cur = '0;
    logic       dis = 1'b0;

    always #5 clk = ~clk;

    legacy_irq_gate u0 (
        .clk(clk), .rst(rst), .pin_req(pin_req), .cmd_wr(cmd_wr),
        .cmd_wdata(cmd_wdata), .cmd_q(cmd_q), .irq_status(irq_status),
        .evt_valid(evt_valid), .evt_pin(evt_pin), .evt_delta(evt_delta)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // At a negedge: expected events for pins in mask, ascending, one per cycle.
    task automatic check_events(input string req, input logic [3:0] mask, input logic [3:0] dirs);
        for (int p = 0; p < 4; p++) begin
            if (mask[p]) begin
                chk({req, " R7 evt_valid"}, 32'(evt_valid), 32'd1);
                chk({req, " R7 evt_pin"}, 32'(evt_pin), 32'(p));
                chk({req, " evt_delta"}, 32'(evt_delta), dirs[p] ? 32'h1 : 32'h3);
                @(negedge clk);
            end
        end
        chk({req, " R2 no further event"}, 32'(evt_valid), 32'd0);
    endtask

    task automatic step_pins(input logic [3:0] nv);
        logic [3:0] m;
        m = dis ? 4'h0 : (cur ^ nv);
        pin_req = nv;
        @(negedge clk);
        chk("R1 irq_status", 32'(irq_status), 32'(|nv));
        check_events(dis ? "R4 disabled" : "R3 pin change", m, nv);
        cur = nv;
    endtask

    task automatic write_cmd(input logic [15:0] wd);
        logic d;
        logic [3:0] m;
        d = wd[10];
        m = (d != dis) ? cur : 4'h0;
        cmd_wr = 1'b1;
        cmd_wdata = wd;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk("R8 cmd_q", 32'(cmd_q), 32'(wd & 16'h0407));
        check_events(d ? "R5 disable set" : "R6 disable clear", m, d ? 4'h0 : 4'hF);
        dis = d;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 reset cmd_q", 32'(cmd_q), 32'd0);
        chk("R9 reset irq_status", 32'(irq_status), 32'd0);
        chk("R9 reset evt_valid", 32'(evt_valid), 32'd0);

        // R2 R3 R7: every pin transition with disable clear
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                step_pins(4'(a));
                step_pins(4'(b));
            end
        end
        step_pins(4'hF);
        step_pins(4'hF);   // R2: repeat same request

        // R5 R6: toggle the disable flag for every pin pattern
        for (int a = 0; a < 16; a++) begin
            step_pins(4'(a));
            write_cmd(16'h0400);
            write_cmd(16'h0400);   // R6: unchanged flag, no event
            write_cmd(16'h0000);
            write_cmd(16'h0003);   // R6: unchanged flag, no event
        end

        // R4 R1: every pin transition with disable set
        write_cmd(16'hFFFF);   // R8: masked bits
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                step_pins(4'(a));
                step_pins(4'(b));
            end
        end
        step_pins(4'b1011);
        write_cmd(16'hFBF8);   // R8 R6: only writable bits land, restores pins

        // R9: reset with pins asserted and enables set
        write_cmd(16'h0407);
        pin_req = 4'b0000;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 reset cmd_q", 32'(cmd_q), 32'd0);
        chk("R9 reset irq_status", 32'(irq_status), 32'd0);
        chk("R9 reset evt_valid", 32'(evt_valid), 32'd0);
        cur = 4'h0;
        dis = 1'b0;
        step_pins(4'b0101);    // R9: contributions start from zero after reset

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule